// File: doc/BRIEF.md
# Host Status Flags and Interrupt Controller

This block holds the status flags and the interrupt line of a sound device's host port. Four flag positions (bits 6 to 3 of the status byte) are set by one-cycle pulses. Two of the pulse sources are built-in interval timers and the rest come in from the outside. A single control byte does two jobs. A write with bit 7 set acknowledges the interrupt. Any other write loads an inverted enable mask and the start bits of the two timers. The host reads a status byte that shows only the enabled flags and a summary bit, with two bits fixed high.

Each timer is an 8-bit up-counter that starts from its own preset register. On overflow it raises its flag and reloads the preset. A shared prescaler sets the tick rates: a fast tick every `TICK_DIV` clocks (80 µs at the default 50 MHz system clock) and a slow tick every `SLOW_RATIO` fast ticks (320 µs by default).

Top module: `hfi_status_irq`

## Requirements
- R1: After reset the status byte reads 0x06, `irq_o` is low, both timer run outputs are low and every flag is disabled (mask all zero).
- R2: A control write with bit 7 set clears all four flags and drops the summary bit and `irq_o`. It leaves the mask and both run bits unchanged.
- R3: A control write with bit 7 clear sets the mask to the complement of data bits 6:3, so a 1 in the data disables that flag. Run 1 takes data bit 0 and run 2 takes data bit 1. Every flag the new mask disables is cleared, and the summary bit and `irq_o` become 1 exactly when some flag remains.
- R4: A flag pulse ORs into the stored flags on the next edge, even when that flag is disabled. If any stored flag is enabled after the update, the summary bit and `irq_o` are 1. Pulses are applied after a control write in the same cycle.
- R5: Once `irq_o` is high it stays high until a control write.
- R6: The status byte is {summary, flags AND mask, 3'b110}: disabled flags read as 0, bits 2 and 1 read 1, bit 0 reads 0, and bit 7 equals `irq_o`.
- R7: A flag stored while disabled stays hidden until a control write enables it. That write then raises the summary bit and `irq_o`.
- R8: Timer 1 loads its preset when its run bit rises, counts up on each fast tick, and on a tick at 0xFF sets flag bit 6 and reloads the preset. With preset P, overflows repeat every (256-P)·`TICK_DIV` clocks.
- R9: Timer 2 behaves the same way on the slow tick and sets flag bit 5.
- R10: A timer whose run bit is low raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_d | input | 8 | Control byte: bit 7 acknowledge, bits 6:3 inverted enables, bits 1:0 timer run |
| preset_we | input | 2 | Preset write strobes, bit 0 timer 1, bit 1 timer 2 |
| preset_d | input | 8 | Preset value |
| ext_flag_i | input | 4 | Flag set pulses for status bits 6:3 (bit 0 maps to status bit 3) |
| stat_q | output | 8 | Status byte as read by the host |
| irq_o | output | 1 | Interrupt request, active high |
| t1_run | output | 1 | Timer 1 start enable |
| t2_run | output | 1 | Timer 2 start enable |

## Verification
Control writes and flag pulses take effect at the edge that samples them. The status byte and `irq_o` are combinational from registers, so the bench's driver applies one stimulus per cycle and queues the expected byte, and the monitor checks it at the next falling edge. A timer flag appears between five and ten clocks after the starting write for timer 1 and within eighteen clocks for timer 2 (with a bench `TICK_DIV` of 4), because the phase of the free-running prescaler is not known. Those checks therefore accept a window, while the gap between two timer 1 overflows is checked as exactly 2·`TICK_DIV` clocks.

// File: rtl/hfi_pkg.sv
package hfi_pkg;

    localparam int FLAG_LO = 3;
    localparam int FLAG_W  = 4;
    localparam int NUM_TMR = 2;

    localparam int CTL_ACK_BIT = 7;
    localparam int CTL_RUN_LO  = 0;

    localparam logic [2:0] RD_LOW_BITS = 3'b110;

    typedef logic [FLAG_W-1:0] flags_t;

    typedef struct packed {
        flags_t               flags;
        flags_t               mask;
        logic                 summary;
        logic [NUM_TMR-1:0]   run;
    } core_state_t;

    function automatic logic [7:0] build_status(input logic summary,
                                                input flags_t flags,
                                                input flags_t mask);
        return {summary, flags & mask, RD_LOW_BITS};
    endfunction

endpackage

// File: rtl/hfi_prescaler.sv
module hfi_prescaler #(
    parameter int TICK_DIV   = 4000,
    parameter int SLOW_RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_fast,
    output logic tick_slow
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int SW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;

    logic [CW-1:0] div_cnt;
    logic [SW-1:0] sub_cnt;

    assign tick_fast = (div_cnt == CW'(TICK_DIV - 1));
    assign tick_slow = tick_fast && (sub_cnt == SW'(SLOW_RATIO - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            sub_cnt <= '0;
        end else begin
            div_cnt <= tick_fast ? '0 : div_cnt + 1'b1;
            if (tick_fast)
                sub_cnt <= tick_slow ? '0 : sub_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hfi_interval_timer.sv
module hfi_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_d,
    output logic             ovf_o
);
    logic [CNT_W-1:0] preset_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             start;

    assign start = run && !run_q;
    assign ovf_o = run && run_q && tick && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            preset_q <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
        end else begin
            run_q <= run;
            if (preset_we)
                preset_q <= preset_d;
            if (start)
                cnt_q <= preset_q;
            else if (ovf_o)
                cnt_q <= preset_q;
            else if (run && tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hfi_flag_core.sv
module hfi_flag_core
    import hfi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_we,
    input  logic [7:0]          ctl_d,
    input  flags_t              evt,
    output core_state_t         st_q
);
    core_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            if (ctl_d[CTL_ACK_BIT]) begin
                st_d.flags   = '0;
                st_d.summary = 1'b0;
            end else begin
                st_d.mask    = ~ctl_d[FLAG_LO +: FLAG_W];
                st_d.run     = ctl_d[CTL_RUN_LO +: NUM_TMR];
                st_d.flags   = st_q.flags & st_d.mask;
                st_d.summary = |st_d.flags;
            end
        end
        st_d.flags = st_d.flags | evt;
        if (|(st_d.flags & st_d.mask))
            st_d.summary = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/hfi_status_irq.sv
module hfi_status_irq
    import hfi_pkg::*;
#(
    parameter int TICK_DIV   = 4000,
    parameter int SLOW_RATIO = 4,
    parameter int CNT_W      = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_we,
    input  logic [7:0]          ctl_d,
    input  logic [1:0]          preset_we,
    input  logic [CNT_W-1:0]    preset_d,
    input  logic [3:0]          ext_flag_i,
    output logic [7:0]          stat_q,
    output logic                irq_o,
    output logic                t1_run,
    output logic                t2_run
);
    logic               tick_fast;
    logic               tick_slow;
    logic [NUM_TMR-1:0] tick_sel;
    logic [NUM_TMR-1:0] ovf;
    flags_t             tmr_flags;
    flags_t             evt_all;
    flags_t             mask_w;
    core_state_t        st;

    hfi_prescaler #(
        .TICK_DIV   (TICK_DIV),
        .SLOW_RATIO (SLOW_RATIO)
    ) u_presc (
        .clk       (clk),
        .rst       (rst),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow)
    );

    assign tick_sel = {tick_slow, tick_fast};

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        hfi_interval_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick_sel[i]),
            .run       (st.run[i]),
            .preset_we (preset_we[i]),
            .preset_d  (preset_d),
            .ovf_o     (ovf[i])
        );
        assign tmr_flags[FLAG_W-1-i] = ovf[i];
    end

    for (genvar j = 0; j < FLAG_W - NUM_TMR; j++) begin : g_pad
        assign tmr_flags[j] = 1'b0;
    end

    assign evt_all = flags_t'(ext_flag_i) | tmr_flags;

    hfi_flag_core u_core (
        .clk    (clk),
        .rst    (rst),
        .ctl_we (ctl_we),
        .ctl_d  (ctl_d),
        .evt    (evt_all),
        .st_q   (st)
    );

    assign mask_w = st.mask;
    assign stat_q = build_status(st.summary, st.flags, st.mask);
    assign irq_o  = st.summary;
    assign t1_run = st.run[0];
    assign t2_run = st.run[1];
endmodule

// File: rtl/hfi_status_irq_chk.sv
module hfi_status_irq_chk
    import hfi_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ctl_we,
    input logic [7:0] ctl_d,
    input flags_t     evt,
    input flags_t     mask,
    input logic [7:0] stat_q,
    input logic       irq_o,
    input logic       t1_run,
    input logic       t2_run
);
    p_ack_clears_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_we && ctl_d[7] && (evt == '0) |=> !irq_o && (stat_q[6:3] == 4'h0));

    p_ack_keeps_cfg_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_we && ctl_d[7] |=> $stable(mask) && $stable(t1_run) && $stable(t2_run));

    p_run_from_data_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_we && !ctl_d[7] |=> (t1_run == $past(ctl_d[0])) && (t2_run == $past(ctl_d[1])));

    p_mask_inverted_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_we && !ctl_d[7] |=> mask == ~$past(ctl_d[6:3]));

    p_enabled_evt_irq_r4: assert property (@(posedge clk) disable iff (rst)
        !ctl_we && (|(evt & mask)) |=> irq_o);

    p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o && !ctl_we |=> irq_o);

    p_fixed_bits_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_q[2:0] == 3'b110) && (stat_q[7] == irq_o));

    p_hidden_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (stat_q[6:3] & ~mask) == 4'h0);
endmodule

bind hfi_status_irq hfi_status_irq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctl_we (ctl_we),
    .ctl_d  (ctl_d),
    .evt    (evt_all),
    .mask   (mask_w),
    .stat_q (stat_q),
    .irq_o  (irq_o),
    .t1_run (t1_run),
    .t2_run (t2_run)
);

// File: tb/sim_hfi_status_irq.sv
module sim_hfi_status_irq;

    localparam int TDIV = 4;
    localparam int SRAT = 4;

    typedef struct {
        logic [7:0] stat;
        logic       irq;
        logic [1:0] run;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_d = '0;
    logic [1:0] preset_we = '0;
    logic [7:0] preset_d = '0;
    logic [3:0] ext_flag_i = '0;
    logic [7:0] stat_q;
    logic       irq_o;
    logic       t1_run;
    logic       t2_run;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    exp_t q[$];

    logic [3:0] m_flags = '0;
    logic [3:0] m_mask  = '0;
    logic       m_sum   = 1'b0;
    logic [1:0] m_run   = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hfi_status_irq #(.TICK_DIV(TDIV), .SLOW_RATIO(SRAT), .CNT_W(8)) u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_d(ctl_d),
        .preset_we(preset_we), .preset_d(preset_d), .ext_flag_i(ext_flag_i),
        .stat_q(stat_q), .irq_o(irq_o), .t1_run(t1_run), .t2_run(t2_run)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Monitor: compares each queued expectation one cycle after its stimulus edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(stat_q == e.stat, {e.tag, " stat"}, stat_q, e.stat);
            check(irq_o == e.irq, {e.tag, " irq"}, irq_o, e.irq);
            check({t2_run, t1_run} == e.run, {e.tag, " run"}, {t2_run, t1_run}, e.run);
        end
    end

    // Driver: one stimulus cycle, model update, expectation pushed
    task automatic step(input bit we, input logic [7:0] d, input logic [3:0] evt, input string tag);
        exp_t e;
        @(negedge clk);
        ctl_we = we; ctl_d = d; ext_flag_i = evt;
        @(posedge clk);
        if (we && d[7]) begin
            m_flags = '0; m_sum = 1'b0;
        end else if (we) begin
            m_mask = ~d[6:3]; m_run = d[1:0];
            m_flags = m_flags & m_mask; m_sum = |m_flags;
        end
        m_flags = m_flags | evt;
        if (|(m_flags & m_mask)) m_sum = 1'b1;
        e.stat = {m_sum, m_flags & m_mask, 3'b110};
        e.irq = m_sum; e.run = m_run; e.tag = tag;
        q.push_back(e);
        #1;
        ctl_we = 1'b0; ext_flag_i = '0;
    endtask

    task automatic raw_wr(input logic [7:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_d = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic set_preset(input int idx, input logic [7:0] v);
        @(negedge clk);
        preset_we[idx] = 1'b1; preset_d = v;
        @(negedge clk);
        preset_we = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_up();
    end

    initial begin
        int w, c1, c2;
        bit seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(stat_q == 8'h06, "R1 stat", stat_q, 8'h06);
        check(irq_o == 1'b0, "R1 irq", irq_o, 0);
        check({t2_run, t1_run} == 2'b00, "R1 run", {t2_run, t1_run}, 0);

        step(0, 8'h00, 4'b0001, "R6 hidden flag under reset mask");
        step(1, 8'h00, 4'b0000, "R7 enable stored flag");
        step(0, 8'h00, 4'b0000, "R5 irq holds");
        step(1, 8'h80, 4'b0000, "R2 acknowledge");
        step(0, 8'h00, 4'b0100, "R4 enabled pulse");
        step(1, 8'h20, 4'b0000, "R3 disable bit5 clears it");
        step(0, 8'h00, 4'b0100, "R4 disabled pulse stored");
        step(1, 8'h00, 4'b0000, "R7 reenable stored flag");
        step(1, 8'h80, 4'b0001, "R4 pulse after same-cycle ack");
        step(1, 8'h80, 4'b0000, "R2 acknowledge again");
        step(1, 8'h78, 4'b0000, "R3 mask all off");
        step(0, 8'h00, 4'b1111, "R6 all hidden");
        step(1, 8'h80, 4'b0000, "R2 clears hidden flags");
        step(1, 8'h00, 4'b0000, "R3 enable with nothing stored");
        step(1, 8'h2B, 4'b0000, "R3 runs set while ack bit clear");
        step(1, 8'h80, 4'b0000, "R2 runs untouched by ack");
        step(1, 8'h00, 4'b0000, "R3 runs cleared");
        repeat (2) @(negedge clk);

        // R8 timer 1 latency, flag position and reload period
        set_preset(0, 8'hFE);
        set_preset(1, 8'hFF);
        repeat (20) @(negedge clk);
        raw_wr(8'h01);
        w = cyc; seen = 0; c1 = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            if (stat_q[6]) begin seen = 1; c1 = cyc; end
            else @(negedge clk);
        end
        check(seen && (c1 - w >= 5) && (c1 - w <= 10), "R8 first overflow delay", c1 - w, 7);
        check(stat_q[5] == 1'b0, "R10 timer2 idle", stat_q[5], 0);
        check(irq_o == 1'b1, "R8 irq", irq_o, 1);
        raw_wr(8'h80);
        seen = 0; c2 = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            if (stat_q[6]) begin seen = 1; c2 = cyc; end
            else @(negedge clk);
        end
        check(seen && (c2 - c1 == 2 * TDIV), "R8 reload period", c2 - c1, 2 * TDIV);

        // R9 timer 2 on slow tick, R10 timer 1 stopped
        raw_wr(8'h80);
        raw_wr(8'h02);
        w = cyc; seen = 0; c1 = 0;
        for (int k = 0; k < 60 && !seen; k++) begin
            if (stat_q[5]) begin seen = 1; c1 = cyc; end
            else @(negedge clk);
        end
        check(seen && (c1 - w >= 1) && (c1 - w <= 18), "R9 timer2 overflow delay", c1 - w, 10);
        check(stat_q[6] == 1'b0, "R10 stopped timer1", stat_q[6], 0);

        raw_wr(8'h80);
        raw_wr(8'h00);
        repeat (200) @(negedge clk);
        check(stat_q == 8'h06, "R10 both stopped stat", stat_q, 8'h06);
        check(irq_o == 1'b0, "R10 both stopped irq", irq_o, 0);
        finish_up();
    end
endmodule